// File: doc/BRIEF.md
# Dispatch Admission and Reorder Buffer

This block sits between a queue of decoded instructions and the out-of-order core. Each cycle it looks at up to `LANES` instructions from the head of that queue, oldest in lane 0, and admits as many as it can, in order, into a reorder buffer. Every instruction states how many micro-ops it has, how many destination registers need renaming, and whether its target scheduler has room. The block tells the queue how many lanes it took, hands out a sequence ID for each admitted instruction, and reports which limit stopped the group.

Execution units send a completion with the sequence ID of a finished instruction. The reorder buffer marks that entry ready and retires finished instructions strictly from the oldest. Retiring returns the instruction's micro-op slots and its rename registers, and the returned resources can be used for dispatch from the next cycle. Renaming tables and schedulers are not modelled. They appear only as a register counter and a per-lane scheduler flag.

Admission is combinational from the lane inputs and the registered occupancy counters. The dispatch lanes are evaluated one after another with a per-lane verdict (admit, or stall for width, reorder space, registers or scheduler), and the first stall verdict ends the group. Retirement is a second in-order scan over up to `RET_W` entries from the head.

Top module: `dispatch_rob`

## Requirements
- R1: After reset, the first admitted instruction gets sequence ID 0, nothing retires, and with no valid lane the stall code is 0 (none).
- R2: Lanes are judged in order from lane 0. The first valid lane that fails any check, and every lane after it, is not admitted that cycle. The lane count stays below the number of valid lanes whenever the stall code is not 0.
- R3: Lane i is admitted only if i < `cfg_width`. A lane refused for this reason gives stall code 1 (width). `cfg_width` = 0 admits nothing.
- R4: An instruction takes as many reorder slots as its micro-op count. The buffer holds `ROB_UOPS` micro-ops in total. An instruction that does not fit gives stall code 2 (reorder space). A group that exactly fills the buffer is admitted.
- R5: With a nonzero `cfg_reg_budget`, the rename registers held by the instructions in flight plus the new ones may not exceed the budget. A refusal for this reason gives stall code 3 (registers).
- R6: A `cfg_reg_budget` of 0 means unbounded: stall code 3 never appears.
- R7: A lane with `in_sched_ok` low is refused with stall code 4 (scheduler). When one lane fails several checks, the code is the first that fails in the order width, reorder space, registers, scheduler.
- R8: Sequence IDs are consecutive modulo `ROB_UOPS`. `disp_id` is the ID of lane 0, and after admitting n lanes it advances by n.
- R9: A completion marks its entry ready one clock later. Each cycle up to `RET_W` ready entries retire, oldest first, starting at `ret_id`. Retirement stops at the first entry that is not ready.
- R10: `ret_regs` is the number of rename registers freed by the instructions retiring this cycle. Their micro-op slots and registers can be used for dispatch from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_width | input | LCW (3) | Dispatch group width, 0 to LANES |
| cfg_reg_budget | input | BUD_W (6) | Rename register budget, 0 = unbounded |
| in_valid | input | LANES (4) | Lane holds a decoded instruction, lane 0 oldest |
| in_uops | input | LANES x UOP_W | Micro-op count per lane (1 or more) |
| in_nregs | input | LANES x NREG_W | Destination registers to rename per lane |
| in_sched_ok | input | LANES | Target scheduler of the lane has room |
| disp_count | output | LCW (3) | Number of lanes admitted this cycle |
| disp_id | output | ID_W (4) | Sequence ID given to lane 0 |
| stall_reason | output | 3 | 0 none, 1 width, 2 reorder space, 3 registers, 4 scheduler |
| cpl_valid | input | 1 | Completion strobe |
| cpl_id | input | ID_W (4) | Sequence ID of the finished instruction |
| ret_count | output | RCW (2) | Instructions retiring this cycle |
| ret_id | output | ID_W (4) | Sequence ID of the oldest entry |
| ret_regs | output | RCNT_W (6) | Rename registers freed this cycle |

## Verification
The hardest case to reach is a stall caused by the exact edge of a resource: a buffer that fits two more micro-ops refusing three and then taking exactly two, or a register budget that is just used up. The bench gets there with occupancy it builds up on purpose. It admits groups of known sizes without completing them, and it moves the register budget between bounded and unbounded so that more registers can be held than a bounded budget would allow. To check in-order retirement, it completes younger entries before the head and then out of order in reverse. A scoreboard queue, filled at dispatch, is compared with every retiring group.

// File: rtl/disp_rob_pkg.sv
package disp_rob_pkg;

    // Verdict for one dispatch lane; the value is also the stall code.
    typedef enum logic [2:0] {
        STALL_NONE  = 3'd0,
        STALL_WIDTH = 3'd1,
        STALL_ROB   = 3'd2,
        STALL_REGS  = 3'd3,
        STALL_SCHED = 3'd4
    } stall_e;

endpackage

// File: rtl/disp_admit.sv
module disp_admit
    import disp_rob_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int UOP_W  = 2,
    parameter int NREG_W = 2,
    parameter int LCW    = 3,
    parameter int UCNT_W = 5,
    parameter int RCNT_W = 6
) (
    input  logic [LCW-1:0]                cfg_width,
    input  logic [LANES-1:0]              in_valid,
    input  logic [LANES-1:0][UOP_W-1:0]   in_uops,
    input  logic [LANES-1:0][NREG_W-1:0]  in_nregs,
    input  logic [LANES-1:0]              in_sched_ok,
    input  logic [UCNT_W-1:0]             rob_free,
    input  logic [RCNT_W-1:0]             reg_free,
    input  logic                          reg_unbounded,
    output logic [LCW-1:0]                take_cnt,
    output logic [UCNT_W-1:0]             take_uops,
    output logic [RCNT_W-1:0]             take_regs,
    output stall_e                        reason
);

    logic [UCNT_W-1:0] rob_left;
    logic [RCNT_W-1:0] reg_left;
    logic              go;
    stall_e            verdict;

    // Lanes are walked oldest first; the first stall verdict closes the group.
    always_comb begin
        rob_left  = rob_free;
        reg_left  = reg_free;
        go        = 1'b1;
        take_cnt  = '0;
        take_uops = '0;
        take_regs = '0;
        reason    = STALL_NONE;
        verdict   = STALL_NONE;
        for (int i = 0; i < LANES; i++) begin
            if (go && in_valid[i]) begin
                if (LCW'(i) >= cfg_width)
                    verdict = STALL_WIDTH;
                else if (UCNT_W'(in_uops[i]) > rob_left)
                    verdict = STALL_ROB;
                else if (!reg_unbounded && (RCNT_W'(in_nregs[i]) > reg_left))
                    verdict = STALL_REGS;
                else if (!in_sched_ok[i])
                    verdict = STALL_SCHED;
                else
                    verdict = STALL_NONE;
                unique case (verdict)
                    STALL_NONE: begin
                        take_cnt  = take_cnt + LCW'(1);
                        take_uops = take_uops + UCNT_W'(in_uops[i]);
                        take_regs = take_regs + RCNT_W'(in_nregs[i]);
                        rob_left  = rob_left - UCNT_W'(in_uops[i]);
                        if (!reg_unbounded)
                            reg_left = reg_left - RCNT_W'(in_nregs[i]);
                    end
                    STALL_WIDTH, STALL_ROB, STALL_REGS, STALL_SCHED: begin
                        reason = verdict;
                        go     = 1'b0;
                    end
                endcase
            end else begin
                go = 1'b0;
            end
        end
    end

endmodule

// File: rtl/rob_table.sv
module rob_table #(
    parameter int DEPTH  = 16,
    parameter int ID_W   = 4,
    parameter int LANES  = 4,
    parameter int RET_W  = 2,
    parameter int UOP_W  = 2,
    parameter int NREG_W = 2,
    parameter int LCW    = 3,
    parameter int RCW    = 2,
    parameter int UCNT_W = 5,
    parameter int RCNT_W = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [LCW-1:0]                wr_cnt,
    input  logic [LANES-1:0][UOP_W-1:0]   wr_uops,
    input  logic [LANES-1:0][NREG_W-1:0]  wr_nregs,
    input  logic                          cpl_valid,
    input  logic [ID_W-1:0]               cpl_id,
    output logic [ID_W-1:0]               tail_id,
    output logic [ID_W-1:0]               head_id,
    output logic [RCW-1:0]                ret_cnt,
    output logic [UCNT_W-1:0]             ret_uops,
    output logic [RCNT_W-1:0]             ret_regs
);

    logic [DEPTH-1:0]  vld_q;
    logic [DEPTH-1:0]  done_q;
    logic [UOP_W-1:0]  uops_q [DEPTH];
    logic [NREG_W-1:0] regs_q [DEPTH];
    logic [ID_W-1:0]   head_q;
    logic [ID_W-1:0]   tail_q;
    logic              rgo;
    logic [ID_W-1:0]   ridx;

    // In-order retire scan from the head; the first entry not ready ends it.
    always_comb begin
        rgo      = 1'b1;
        ret_cnt  = '0;
        ret_uops = '0;
        ret_regs = '0;
        ridx     = head_q;
        for (int k = 0; k < RET_W; k++) begin
            ridx = head_q + ID_W'(k);
            if (rgo && vld_q[ridx] && done_q[ridx]) begin
                ret_cnt  = ret_cnt + RCW'(1);
                ret_uops = ret_uops + UCNT_W'(uops_q[ridx]);
                ret_regs = ret_regs + RCNT_W'(regs_q[ridx]);
            end else begin
                rgo = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= '0;
            done_q <= '0;
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (cpl_valid && vld_q[cpl_id])
                done_q[cpl_id] <= 1'b1;
            for (int k = 0; k < RET_W; k++) begin
                if (RCW'(k) < ret_cnt) begin
                    vld_q[head_q + ID_W'(k)]  <= 1'b0;
                    done_q[head_q + ID_W'(k)] <= 1'b0;
                end
            end
            for (int i = 0; i < LANES; i++) begin
                if (LCW'(i) < wr_cnt) begin
                    vld_q[tail_q + ID_W'(i)]  <= 1'b1;
                    done_q[tail_q + ID_W'(i)] <= 1'b0;
                    uops_q[tail_q + ID_W'(i)] <= wr_uops[i];
                    regs_q[tail_q + ID_W'(i)] <= wr_nregs[i];
                end
            end
            head_q <= head_q + ID_W'(ret_cnt);
            tail_q <= tail_q + ID_W'(wr_cnt);
        end
    end

    assign head_id = head_q;
    assign tail_id = tail_q;

endmodule

// File: rtl/dispatch_rob.sv
module dispatch_rob
    import disp_rob_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int RET_W    = 2,
    parameter int ROB_UOPS = 16,
    parameter int UOP_W    = 2,
    parameter int NREG_W   = 2,
    parameter int BUD_W    = 6,
    localparam int ID_W    = $clog2(ROB_UOPS),
    localparam int LCW     = $clog2(LANES + 1),
    localparam int RCW     = $clog2(RET_W + 1),
    localparam int MAXREG  = ROB_UOPS * ((1 << NREG_W) - 1),
    localparam int RCNT_A  = $clog2(MAXREG + 1),
    localparam int RCNT_W  = (RCNT_A > BUD_W) ? RCNT_A : BUD_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [LCW-1:0]                cfg_width,
    input  logic [BUD_W-1:0]              cfg_reg_budget,
    input  logic [LANES-1:0]              in_valid,
    input  logic [LANES-1:0][UOP_W-1:0]   in_uops,
    input  logic [LANES-1:0][NREG_W-1:0]  in_nregs,
    input  logic [LANES-1:0]              in_sched_ok,
    output logic [LCW-1:0]                disp_count,
    output logic [ID_W-1:0]               disp_id,
    output logic [2:0]                    stall_reason,
    input  logic                          cpl_valid,
    input  logic [ID_W-1:0]               cpl_id,
    output logic [RCW-1:0]                ret_count,
    output logic [ID_W-1:0]               ret_id,
    output logic [RCNT_W-1:0]             ret_regs
);

    localparam int UCNT_W = $clog2(ROB_UOPS + 1);

    logic [UCNT_W-1:0] uops_used_q;
    logic [RCNT_W-1:0] regs_used_q;
    logic [UCNT_W-1:0] rob_free;
    logic [RCNT_W-1:0] reg_free;
    logic [RCNT_W-1:0] budget_x;
    logic              reg_unbounded;
    logic [LCW-1:0]    take_cnt;
    logic [UCNT_W-1:0] take_uops;
    logic [RCNT_W-1:0] take_regs;
    logic [UCNT_W-1:0] ret_uops;
    logic [RCNT_W-1:0] ret_regs_w;
    stall_e            reason;

    always_comb begin
        budget_x      = RCNT_W'(cfg_reg_budget);
        reg_unbounded = (cfg_reg_budget == '0);
        rob_free      = UCNT_W'(ROB_UOPS) - uops_used_q;
        reg_free      = (budget_x > regs_used_q) ? (budget_x - regs_used_q) : '0;
    end

    // Occupancy counters: admitted resources in, retired resources out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uops_used_q <= '0;
            regs_used_q <= '0;
        end else begin
            uops_used_q <= uops_used_q + take_uops - ret_uops;
            regs_used_q <= regs_used_q + take_regs - ret_regs_w;
        end
    end

    disp_admit #(
        .LANES(LANES), .UOP_W(UOP_W), .NREG_W(NREG_W),
        .LCW(LCW), .UCNT_W(UCNT_W), .RCNT_W(RCNT_W)
    ) u_admit (
        .cfg_width     (cfg_width),
        .in_valid      (in_valid),
        .in_uops       (in_uops),
        .in_nregs      (in_nregs),
        .in_sched_ok   (in_sched_ok),
        .rob_free      (rob_free),
        .reg_free      (reg_free),
        .reg_unbounded (reg_unbounded),
        .take_cnt      (take_cnt),
        .take_uops     (take_uops),
        .take_regs     (take_regs),
        .reason        (reason)
    );

    rob_table #(
        .DEPTH(ROB_UOPS), .ID_W(ID_W), .LANES(LANES), .RET_W(RET_W),
        .UOP_W(UOP_W), .NREG_W(NREG_W), .LCW(LCW), .RCW(RCW),
        .UCNT_W(UCNT_W), .RCNT_W(RCNT_W)
    ) u_rob (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_cnt    (take_cnt),
        .wr_uops   (in_uops),
        .wr_nregs  (in_nregs),
        .cpl_valid (cpl_valid),
        .cpl_id    (cpl_id),
        .tail_id   (disp_id),
        .head_id   (ret_id),
        .ret_cnt   (ret_count),
        .ret_uops  (ret_uops),
        .ret_regs  (ret_regs_w)
    );

    always_comb begin
        disp_count   = take_cnt;
        stall_reason = reason;
        ret_regs     = ret_regs_w;
    end

endmodule

// File: rtl/dispatch_rob_chk.sv
module dispatch_rob_chk #(
    parameter int LANES = 4,
    parameter int RET_W = 2,
    parameter int ID_W  = 4,
    parameter int LCW   = 3,
    parameter int RCW   = 2,
    parameter int BUD_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LCW-1:0]   cfg_width,
    input logic [BUD_W-1:0] cfg_reg_budget,
    input logic [LANES-1:0] in_valid,
    input logic [LCW-1:0]   disp_count,
    input logic [ID_W-1:0]  disp_id,
    input logic [2:0]       stall_reason,
    input logic [RCW-1:0]   ret_count,
    input logic [ID_W-1:0]  ret_id
);

    // R3
    group_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_count <= cfg_width);

    // R2
    stall_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_reason != 3'd0) |-> (32'(disp_count) < $countones(in_valid)));

    // R6
    unbounded_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_reg_budget == '0) |-> (stall_reason != 3'd3));

    // R8
    seq_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_count != '0) |=> (disp_id == $past(disp_id) + ID_W'($past(disp_count))));

    // R8
    seq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_count == '0) |=> $stable(disp_id));

    // R9
    retire_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_count != '0) |=> (ret_id == $past(ret_id) + ID_W'($past(ret_count))));

    // R9
    retire_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(ret_count) <= RET_W);

endmodule

bind dispatch_rob dispatch_rob_chk #(
    .LANES(LANES), .RET_W(RET_W), .ID_W(ID_W),
    .LCW(LCW), .RCW(RCW), .BUD_W(BUD_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_width      (cfg_width),
    .cfg_reg_budget (cfg_reg_budget),
    .in_valid       (in_valid),
    .disp_count     (disp_count),
    .disp_id        (disp_id),
    .stall_reason   (stall_reason),
    .ret_count      (ret_count),
    .ret_id         (ret_id)
);

// File: tb/dispatch_rob_bench.sv
module dispatch_rob_bench;

    localparam int LANES = 4;
    localparam int DEPTH = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       cfg_width = 3'd4;
    logic [5:0]       cfg_reg_budget = 6'd0;
    logic [3:0]       in_valid = '0;
    logic [3:0][1:0]  in_uops = '0;
    logic [3:0][1:0]  in_nregs = '0;
    logic [3:0]       in_sched_ok = '0;
    logic [2:0]       disp_count;
    logic [3:0]       disp_id;
    logic [2:0]       stall_reason;
    logic             cpl_valid = 1'b0;
    logic [3:0]       cpl_id = '0;
    logic [1:0]       ret_count;
    logic [3:0]       ret_id;
    logic [5:0]       ret_regs;

    typedef struct { int id; int regs; } exp_t;
    exp_t exp_q[$];

    int nchk = 0;
    int nbad = 0;
    bit reported = 0;

    int st_u [LANES];
    int st_r [LANES];
    bit st_s [LANES];
    bit st_v [LANES];

    dispatch_rob u_dispatch_rob (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_reg_budget(cfg_reg_budget),
        .in_valid(in_valid), .in_uops(in_uops), .in_nregs(in_nregs), .in_sched_ok(in_sched_ok),
        .disp_count(disp_count), .disp_id(disp_id), .stall_reason(stall_reason),
        .cpl_valid(cpl_valid), .cpl_id(cpl_id),
        .ret_count(ret_count), .ret_id(ret_id), .ret_regs(ret_regs)
    );

    always #10 clk = ~clk;

    task automatic check(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1;
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
        end
    endtask

    task automatic clear_lanes();
        for (int i = 0; i < LANES; i++) begin
            st_v[i] = 0; st_u[i] = 1; st_r[i] = 0; st_s[i] = 1;
        end
    endtask

    task automatic lane(int i, int u, int r, bit s);
        st_v[i] = 1; st_u[i] = u; st_r[i] = r; st_s[i] = s;
    endtask

    // Driver: applies staged lanes, checks admission, pushes expected retirements.
    task automatic fire(int w, int exp_id, int exp_cnt, int exp_reason, string tag);
        @(negedge clk);
        cfg_width = 3'(w);
        for (int i = 0; i < LANES; i++) begin
            in_valid[i]    = st_v[i];
            in_uops[i]     = 2'(st_u[i]);
            in_nregs[i]    = 2'(st_r[i]);
            in_sched_ok[i] = st_s[i];
        end
        #1;
        check({tag, " id"}, int'(disp_id), exp_id);
        check({tag, " count"}, int'(disp_count), exp_cnt);
        check({tag, " reason"}, int'(stall_reason), exp_reason);
        for (int i = 0; i < int'(disp_count); i++)
            exp_q.push_back('{id: (int'(disp_id) + i) % DEPTH, regs: st_r[i]});
        @(posedge clk);
        #1;
        in_valid = '0;
        clear_lanes();
    endtask

    task automatic complete(int id);
        @(negedge clk);
        cpl_valid = 1'b1;
        cpl_id = 4'(id);
        @(posedge clk);
        #1;
        cpl_valid = 1'b0;
    endtask

    // Monitor: scoreboard of retiring groups against dispatch order.
    always @(negedge clk) begin
        #2;
        if (rst_n && ret_count != '0) begin
            int sum;
            sum = 0;
            for (int k = 0; k < int'(ret_count); k++) begin
                if (exp_q.size() == 0) begin
                    check("R9 retire with empty scoreboard", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check("R9 retire order", (int'(ret_id) + k) % DEPTH, e.id);
                    sum += e.regs;
                end
            end
            check("R10 freed registers", int'(ret_regs), sum);
        end
    end

    initial begin
        #(20 * 100000);
        check("watchdog expired", 1, 0);
        summary();
        $finish;
    end

    initial begin
        clear_lanes();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        check("R1 reset disp_id", int'(disp_id), 0);
        check("R1 reset ret_count", int'(ret_count), 0);
        check("R1 reset stall none", int'(stall_reason), 0);
        check("R1 reset disp_count", int'(disp_count), 0);

        // R3: width 2 caps a three-lane offer
        cfg_reg_budget = 6'd6;
        lane(0, 1, 1, 1); lane(1, 1, 1, 1); lane(2, 1, 1, 1);
        fire(2, 0, 2, 1, "R3 width cap");

        // R5: 4 of 6 registers left; 3 fits, then 2 does not
        lane(0, 1, 3, 1); lane(1, 1, 2, 1);
        fire(4, 2, 1, 3, "R5 register limit");

        // R6: budget 0 admits beyond any bound
        cfg_reg_budget = 6'd0;
        lane(0, 1, 3, 1); lane(1, 1, 3, 1);
        fire(4, 3, 2, 0, "R6 unbounded");

        // R4: 11 free micro-op slots, four 3-uop lanes
        lane(0, 3, 0, 1); lane(1, 3, 0, 1); lane(2, 3, 0, 1); lane(3, 3, 0, 1);
        fire(4, 5, 3, 2, "R4 rob partial");
        lane(0, 3, 0, 1);
        fire(4, 8, 0, 2, "R4 rob too big");
        lane(0, 2, 0, 1);
        fire(4, 8, 1, 0, "R4 rob exact fill");
        lane(0, 1, 0, 1);
        fire(4, 9, 0, 2, "R4 rob full");

        // R9: younger completions do not retire past the head
        complete(1);
        @(negedge clk); #1;
        check("R9 head not ready", int'(ret_count), 0);
        complete(2);
        @(negedge clk); #1;
        check("R9 head still not ready", int'(ret_count), 0);
        complete(0);
        @(negedge clk); #1;
        check("R9 retire width cap", int'(ret_count), 2);
        check("R9 retire start id", int'(ret_id), 0);
        @(negedge clk); #1;
        check("R9 retire remaining", int'(ret_count), 1);
        check("R9 retire next id", int'(ret_id), 2);

        for (int id = 8; id >= 3; id--) complete(id);
        repeat (6) @(posedge clk);
        check("R9 scoreboard drained", exp_q.size(), 0);

        // R10: all registers and slots returned; budget 6 again binds
        cfg_reg_budget = 6'd6;
        lane(0, 1, 3, 1); lane(1, 1, 3, 1); lane(2, 1, 1, 1);
        fire(4, 9, 2, 3, "R10 resources returned");

        // R3: width zero admits nothing
        cfg_reg_budget = 6'd0;
        lane(0, 1, 0, 1);
        fire(0, 11, 0, 1, "R3 width zero");

        // R7 and R2: scheduler refusal halts younger lanes
        lane(0, 1, 1, 1); lane(1, 1, 1, 0); lane(2, 1, 1, 1);
        fire(4, 11, 1, 4, "R7 scheduler stall");
        lane(0, 1, 1, 1);
        fire(4, 12, 1, 0, "R2 younger lane not passed");

        // R7: width wins over scheduler on the same lane
        lane(0, 1, 0, 1); lane(1, 1, 0, 0);
        fire(1, 13, 1, 1, "R7 priority width");

        for (int id = 9; id <= 13; id++) complete(id);
        repeat (6) @(posedge clk);
        check("R9 final drain", exp_q.size(), 0);

        summary();
        $finish;
    end

endmodule